// File: doc/BRIEF.md
# Program Counter and Branch Sequencer

This block owns the program counter of a small 8-bit processor core. Each accepted instruction arrives already classified by the decoder, together with a signed relative offset, a status-bit index and polarity, the status register and three skip-test results: one bit taken from a general register, one bit taken from an I/O register, and a register-equality flag. From these the block computes the next program counter, keeps return addresses for calls in a three-entry hardware stack, and reports how long each control-flow instruction occupies the core.

Instruction fetch watches `busy`. An instruction is accepted on a clock edge where `issue` is high and `busy` is low. The new program counter is visible right after that edge. `busy` then stays high for the extra cycles the instruction costs, and `issue` is ignored for as long as it does. A return from an interrupt handler also raises `ie_set` for one cycle, so that the status logic can set the global interrupt enable.

Top module: `flow_sequencer`

## Requirements
- R1: After reset, `pc` is 0, `busy` is 0, `ie_set` is 0, and every return-stack entry holds 0, so a return issued straight after reset goes to address 0.
- R2: Opcode 0 (sequential) and any unlisted opcode (11 to 15) load `pc + 1` and take 1 cycle.
- R3: Opcode 1 (relative jump) loads `pc + offset + 1`, wrapping modulo 1024, and takes 2 cycles.
- R4: Opcode 2 (relative call) loads `pc + offset + 1`, pushes `pc + 1` onto the return stack and takes 3 cycles.
- R5: Opcode 3 (return) and opcode 4 (interrupt return) pop the return stack into `pc` and take 4 cycles. Opcode 4 also drives `ie_set` high for exactly the one cycle after its acceptance edge.
- R6: Opcode 5 (status branch) is taken when `sreg[bit_sel]` equals `br_on_set`. Status bit order is I=7, T=6, H=5, S=4, V=3, N=2, Z=1, C=0, so the signed greater-or-equal and less-than tests are index 4. A taken branch loads `pc + offset + 1` and takes 2 cycles. A branch that is not taken loads `pc + 1` and takes 1 cycle.
- R7: The skip opcodes and their conditions are: 6 skips when `reg_bit` is 0, 7 when `reg_bit` is 1, 8 when `io_bit` is 0, 9 when `io_bit` is 1, and 10 when `regs_eq` is 1. A skip whose condition holds loads `pc + 2` and takes 2 cycles. Otherwise the opcode loads `pc + 1` and takes 1 cycle.
- R8: The return stack holds 3 entries and behaves last-in first-out. A push when all 3 entries are in use discards the oldest one. A pop with no entries in use returns the bottom entry again.
- R9: An instruction of N cycles holds `busy` high for the N-1 cycles after its acceptance edge. While `busy` is high, `issue` has no effect on `pc`, on the stack or on `ie_set`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| issue | input | 1 | A decoded instruction is offered this cycle |
| op | input | 4 | Instruction class code (see R2 to R7) |
| offset | input | 10 | Signed relative offset, taken modulo the program space |
| bit_sel | input | 3 | Status bit index for the status branch |
| br_on_set | input | 1 | 1: branch when the bit is set; 0: branch when it is clear |
| sreg | input | 8 | Status register |
| reg_bit | input | 1 | Selected bit of a general register |
| io_bit | input | 1 | Selected bit of an I/O register |
| regs_eq | input | 1 | The two compared registers are equal |
| pc | output | 10 | Program counter |
| busy | output | 1 | Extra cycles of a multi-cycle instruction in progress |
| ie_set | output | 1 | One-cycle request to set the global interrupt enable |

## Verification
The assertions assume that `issue` is meaningful only when `busy` is low, and that the decoder holds `op` to the listed codes whenever it wants a defined class. The bench keeps to this by releasing `issue` before `busy` falls. It raises `issue` with random jump requests only in cycles where it has already seen `busy` high. Opcodes, offsets, status values and skip inputs are drawn at random, weighted so that the stack regularly overflows and underflows. Directed cases add a return straight after reset, a wrap past address 1023, and a signed-compare branch on index 4.

// File: rtl/flow_seq_pkg.sv
// Shared widths and instruction class codes for the branch sequencer.
// Assumes a 10-bit word-addressed program space.
package flow_seq_pkg;
    localparam int PC_W     = 10;
    localparam int STK_DEPTH = 3;
    localparam int OP_W     = 4;

    typedef enum logic [OP_W-1:0] {
        OP_SEQ    = 4'd0,
        OP_RJMP   = 4'd1,
        OP_RCALL  = 4'd2,
        OP_RET    = 4'd3,
        OP_RETI   = 4'd4,
        OP_BRANCH = 4'd5,
        OP_SK_RBC = 4'd6,
        OP_SK_RBS = 4'd7,
        OP_SK_IOC = 4'd8,
        OP_SK_IOS = 4'd9,
        OP_SK_EQ  = 4'd10
    } flow_op_e;
endpackage

// File: rtl/flow_retstack.sv
// Return-address stack built as a shift register.
// Entry 0 is the top. A push shifts every entry down and drops the oldest.
// A pop shifts up and copies the bottom entry into the slot it leaves, so a
// pop from an empty stack yields the bottom entry.
// Assumes push and pop are never high together.
module flow_retstack #(
    parameter int W     = 10,
    parameter int DEPTH = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] push_val,
    output logic [W-1:0] top_val
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     ent [DEPTH];
    logic [CNT_W-1:0] used;

    // Per-entry shift on push or pop.
    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        if (i == 0) begin : g_top
            always_ff @(posedge clk) begin
                if (!rst_n)    ent[i] <= '0;
                else if (push) ent[i] <= push_val;
                else if (pop)  ent[i] <= ent[i+1];
            end
        end else if (i == DEPTH - 1) begin : g_bot
            always_ff @(posedge clk) begin
                if (!rst_n)    ent[i] <= '0;
                else if (push) ent[i] <= ent[i-1];
            end
        end else begin : g_mid
            always_ff @(posedge clk) begin
                if (!rst_n)    ent[i] <= '0;
                else if (push) ent[i] <= ent[i-1];
                else if (pop)  ent[i] <= ent[i+1];
            end
        end
    end

    // Saturating occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n)                              used <= '0;
        else if (push && used != CNT_W'(DEPTH))  used <= used + 1'b1;
        else if (pop && used != '0)              used <= used - 1'b1;
    end

    assign top_val = ent[0];

    // R8: the count never exceeds the depth.
    a_r8_used_bound: assert property (@(posedge clk) disable iff (!rst_n)
        used <= CNT_W'(DEPTH));
    // R8: an empty stack holds only copies of the bottom entry.
    a_r8_empty_uniform: assert property (@(posedge clk) disable iff (!rst_n)
        (used == '0) |-> (ent[0] == ent[DEPTH-1]));
    // R8: a push makes its value the new top.
    a_r8_push_top: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> (top_val == $past(push_val)));
endmodule

// File: rtl/flow_cond.sv
// Condition evaluation for status branches and skips.
// Produces the taken/skip decision for the current class. The result
// matters only for the branch and skip classes.
module flow_cond
    import flow_seq_pkg::*;
#(
    parameter int SR_W = 8
) (
    input  flow_op_e                    op,
    input  logic [$clog2(SR_W)-1:0]     bit_sel,
    input  logic                        br_on_set,
    input  logic [SR_W-1:0]             sreg,
    input  logic                        reg_bit,
    input  logic                        io_bit,
    input  logic                        regs_eq,
    output logic                        cond_true
);
    // Select the condition that belongs to the class.
    always_comb begin
        unique case (op)
            OP_BRANCH: cond_true = (sreg[bit_sel] == br_on_set);
            OP_SK_RBC: cond_true = !reg_bit;
            OP_SK_RBS: cond_true = reg_bit;
            OP_SK_IOC: cond_true = !io_bit;
            OP_SK_IOS: cond_true = io_bit;
            OP_SK_EQ:  cond_true = regs_eq;
            default:   cond_true = 1'b0;
        endcase
    end
endmodule

// File: rtl/flow_stall.sv
// Stall counter. It is loaded with the extra cycle count of an accepted
// instruction and counts down. busy is high while it is non-zero.
module flow_stall #(
    parameter int MAX_EXTRA = 3
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             load,
    input  logic [$clog2(MAX_EXTRA+1)-1:0]   extra,
    output logic                             busy
);
    localparam int CW = $clog2(MAX_EXTRA + 1);

    logic [CW-1:0] remain;

    // Load on acceptance, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)           remain <= '0;
        else if (load)        remain <= extra;
        else if (remain != '0) remain <= remain - 1'b1;
    end

    assign busy = (remain != '0);

    // R9: load is never requested while stalled.
    a_r9_no_load_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !load);
    // R9: the stall decreases by one each cycle.
    a_r9_countdown: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !load) |=> (remain == $past(remain) - 1'b1));
endmodule

// File: rtl/flow_sequencer.sv
// Top of the program-flow unit. It computes the next program counter for each
// accepted instruction class, drives the return stack and loads the stall
// counter with the extra cycles. The new pc is visible right after the
// acceptance edge. The caller must hold issue to meaningful codes.
module flow_sequencer
    import flow_seq_pkg::*;
#(
    parameter int          PCW      = PC_W,
    parameter int          DEPTH    = STK_DEPTH,
    parameter logic [9:0]  RESET_PC = 10'd0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            issue,
    input  logic [3:0]      op,
    input  logic [PCW-1:0]  offset,
    input  logic [2:0]      bit_sel,
    input  logic            br_on_set,
    input  logic [7:0]      sreg,
    input  logic            reg_bit,
    input  logic            io_bit,
    input  logic            regs_eq,
    output logic [PCW-1:0]  pc,
    output logic            busy,
    output logic            ie_set
);
    localparam int MAX_EXTRA = 3;
    localparam int EX_W      = $clog2(MAX_EXTRA + 1);

    flow_op_e        cls;
    logic            accept;
    logic            cond_true;
    logic [PCW-1:0]  pc_q;
    logic [PCW-1:0]  pc_nxt;
    logic [PCW-1:0]  pc_inc;
    logic [PCW-1:0]  pc_rel;
    logic [PCW-1:0]  stk_top;
    logic [EX_W-1:0] extra;
    logic            do_push;
    logic            do_pop;
    logic            is_reti;
    logic            ie_q;

    assign cls    = flow_op_e'(op);
    assign accept = issue && !busy;
    assign pc_inc = pc_q + 1'b1;
    assign pc_rel = pc_q + offset + 1'b1;

    flow_cond #(.SR_W(8)) u_cond (
        .op        (cls),
        .bit_sel   (bit_sel),
        .br_on_set (br_on_set),
        .sreg      (sreg),
        .reg_bit   (reg_bit),
        .io_bit    (io_bit),
        .regs_eq   (regs_eq),
        .cond_true (cond_true)
    );

    flow_retstack #(.W(PCW), .DEPTH(DEPTH)) u_stack (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (accept && do_push),
        .pop      (accept && do_pop),
        .push_val (pc_inc),
        .top_val  (stk_top)
    );

    flow_stall #(.MAX_EXTRA(MAX_EXTRA)) u_stall (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .extra (extra),
        .busy  (busy)
    );

    // Next pc, extra cycles and stack action per class.
    always_comb begin
        pc_nxt  = pc_inc;
        extra   = '0;
        do_push = 1'b0;
        do_pop  = 1'b0;
        is_reti = 1'b0;
        case (cls)
            OP_RJMP: begin
                pc_nxt = pc_rel;
                extra  = EX_W'(1);
            end
            OP_RCALL: begin
                pc_nxt  = pc_rel;
                extra   = EX_W'(2);
                do_push = 1'b1;
            end
            OP_RET, OP_RETI: begin
                pc_nxt  = stk_top;
                extra   = EX_W'(3);
                do_pop  = 1'b1;
                is_reti = (cls == OP_RETI);
            end
            OP_BRANCH: begin
                if (cond_true) begin
                    pc_nxt = pc_rel;
                    extra  = EX_W'(1);
                end
            end
            OP_SK_RBC, OP_SK_RBS, OP_SK_IOC, OP_SK_IOS, OP_SK_EQ: begin
                if (cond_true) begin
                    pc_nxt = pc_q + PCW'(2);
                    extra  = EX_W'(1);
                end
            end
            default: ;
        endcase
    end

    // Program counter and the interrupt-enable pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= RESET_PC[PCW-1:0];
            ie_q <= 1'b0;
        end else begin
            ie_q <= accept && is_reti;
            if (accept) pc_q <= pc_nxt;
        end
    end

    assign pc     = pc_q;
    assign ie_set = ie_q;

    // R2: a sequential instruction advances by one.
    a_r2_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cls == OP_SEQ) |=> (pc == $past(pc) + 1'b1) && !busy);
    // R4: a call is followed by a stall.
    a_r4_call_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cls == OP_RCALL) |=> busy);
    // R5: the interrupt-enable request lasts a single cycle.
    a_r5_ie_single: assert property (@(posedge clk) disable iff (!rst_n)
        ie_set |=> !ie_set);
    // R5: the interrupt-enable request appears only during a stall.
    a_r5_ie_in_stall: assert property (@(posedge clk) disable iff (!rst_n)
        ie_set |-> busy);
    // R9: pc holds while stalled.
    a_r9_pc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(pc));
endmodule

// File: tb/tb_flow_sequencer.sv
`timescale 1ns/1ps
module tb_flow_sequencer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       issue = 1'b0;
    logic [3:0] op = 4'd0;
    logic [9:0] offset = '0;
    logic [2:0] bit_sel = '0;
    logic       br_on_set = 1'b0;
    logic [7:0] sreg = '0;
    logic       reg_bit = 1'b0, io_bit = 1'b0, regs_eq = 1'b0;
    logic [9:0] pc;
    logic       busy, ie_set;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [9:0] mpc;
    logic [9:0] mstk [3];

    always #2.5 clk = ~clk;

    flow_sequencer dut (
        .clk(clk), .rst_n(rst_n), .issue(issue), .op(op), .offset(offset),
        .bit_sel(bit_sel), .br_on_set(br_on_set), .sreg(sreg),
        .reg_bit(reg_bit), .io_bit(io_bit), .regs_eq(regs_eq),
        .pc(pc), .busy(busy), .ie_set(ie_set)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Issue one instruction, update the model and check every cycle it takes.
    task automatic run(input int o, input logic [9:0] k, input int bs, input bit pol,
                       input logic [7:0] sr, input bit rb, input bit iob, input bit eq,
                       input bit junk);
        logic [9:0] e;
        int         cyc;
        bit         t;
        string      req;
        e = mpc + 10'd1; cyc = 1; req = "R2";
        case (o)
            1: begin e = mpc + k + 10'd1; cyc = 2; req = "R3"; end
            2: begin
                e = mpc + k + 10'd1; cyc = 3; req = "R4";
                mstk[2] = mstk[1]; mstk[1] = mstk[0]; mstk[0] = mpc + 10'd1;
            end
            3, 4: begin
                e = mstk[0]; cyc = 4; req = "R5";
                mstk[0] = mstk[1]; mstk[1] = mstk[2];
            end
            5: begin
                t = (sr[bs] == pol); req = "R6";
                if (t) begin e = mpc + k + 10'd1; cyc = 2; end
            end
            6, 7, 8, 9, 10: begin
                t = (o == 6) ? !rb : (o == 7) ? rb : (o == 8) ? !iob : (o == 9) ? iob : eq;
                req = "R7";
                if (t) begin e = mpc + 10'd2; cyc = 2; end
            end
            default: ;
        endcase
        @(negedge clk);
        op = 4'(o); offset = k; bit_sel = 3'(bs); br_on_set = pol; sreg = sr;
        reg_bit = rb; io_bit = iob; regs_eq = eq; issue = 1'b1;
        @(negedge clk);
        mpc = e;
        chk({req, " pc"}, int'(pc), int'(e));
        chk({req, " busy first"}, int'(busy), int'(cyc > 1));
        chk("R5 ie_set", int'(ie_set), int'(o == 4));
        issue = junk && (cyc > 1);
        if (issue) begin op = 4'd1; offset = 10'($urandom); end
        for (int j = 1; j < cyc; j++) begin
            @(negedge clk);
            chk("R9 busy hold", int'(busy), int'(j < cyc - 1));
            chk("R9 pc stable", int'(pc), int'(e));
            issue = junk && (j < cyc - 1);
        end
        issue = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        int r;
        void'($urandom(32'd1234));
        mpc = '0;
        for (int i = 0; i < 3; i++) mstk[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 pc", int'(pc), 0);
        chk("R1 busy", int'(busy), 0);
        chk("R1 ie_set", int'(ie_set), 0);
        // R1: a return straight after reset goes to 0
        run(0, 0, 0, 0, 0, 0, 0, 0, 0);
        run(3, 0, 0, 0, 0, 0, 0, 0, 0);
        // R3: wrap past the top of the program space
        run(1, 10'd1018, 0, 0, 0, 0, 0, 0, 0);
        run(1, 10'd5, 0, 0, 0, 0, 0, 0, 1);
        // R6: signed compare uses index 4
        run(5, 10'd20, 4, 1, 8'h10, 0, 0, 0, 0);
        run(5, 10'd20, 4, 1, 8'h0C, 0, 0, 0, 0);
        // R8: overflow, then underflow, then a pop from the empty stack
        for (int i = 0; i < 4; i++) run(2, 10'(40 * i + 7), 0, 0, 0, 0, 0, 0, 0);
        for (int i = 0; i < 5; i++) run((i == 2) ? 4 : 3, 0, 0, 0, 0, 0, 0, 0, 1);
        // R7: every skip class, true and false
        for (int o = 6; o <= 10; o++) begin
            run(o, 0, 0, 0, 0, 0, 0, 0, 0);
            run(o, 0, 0, 0, 0, 1, 1, 1, 0);
        end
        // Random mix
        for (int n = 0; n < 800; n++) begin
            int o;
            r = int'($urandom % 16);
            if (r < 2)       o = 0;
            else if (r < 3)  o = 11 + int'($urandom % 5);
            else if (r < 5)  o = 1;
            else if (r < 7)  o = 2;
            else if (r < 9)  o = 3;
            else if (r < 10) o = 4;
            else if (r < 13) o = 5;
            else             o = 6 + int'($urandom % 5);
            run(o, 10'($urandom), int'($urandom % 8), 1'($urandom), 8'($urandom),
                1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
        end
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule